// File: doc/BRIEF.md
# IO bank freeze/thaw sequencer

This block parks the pad-control lines of a set of general-purpose IO channels in a safe "frozen" condition and later restores them, one channel after another. Each channel carries five lines. Slew enable, weak pull-up, tristate and bus-hold are active-low. Configuration-done is active-high. Out of reset every channel is frozen.

A one-cycle freeze or thaw request starts a fixed, ordered series of steps. Consecutive steps are separated by a minimum gap. That gap is given in nanoseconds, together with the clock frequency, and is turned into a whole number of clocks. The channels are handled in ascending order. A per-channel status bit reports whether the channel is frozen. A busy flag covers the whole series, and a one-cycle done pulse closes it.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, all channels are frozen and `frozen` is all ones. All of `slew_n`, `pullup_n`, `tri_n`, `hold_n` and `cfg_done` are 0. `busy` and `done` are 0.
- R2: The first freeze step for a channel drives its `slew_n`, `pullup_n` and `tri_n` to 0 in the same cycle. The step is applied on the clock edge that samples the request (channel 0) or the edge that ends the previous gap.
- R3: The second freeze step comes GAP cycles after the first. It drives `hold_n` and `cfg_done` to 0 together, and sets that channel's `frozen` bit in the same cycle.
- R4: The first thaw step drives `hold_n` to 1 and `cfg_done` to 1 together.
- R5: The second thaw step comes GAP cycles after the first and drives `pullup_n` and `tri_n` to 1.
- R6: The third thaw step comes GAP cycles after the second and drives `slew_n` to 1. The channel's `frozen` bit clears in that same cycle and not before.
- R7: Channels are processed in ascending order, 0 first. All steps of one channel complete before the next channel starts, and no two channels change in the same cycle.
- R8: GAP = ceil(GAP_NS*CLK_MHZ/1000) clock cycles, at least 1. With the defaults (200 MHz, 20 ns), GAP is 4. Every step, including the last one, is followed by exactly GAP cycles before the next step or the end.
- R9: `busy` is 1 from the cycle after the accepting edge until the end of the series. `done` is high for exactly one cycle, GAP cycles after the last step, with `busy` 0 in that cycle.
- R10: A freeze or thaw request that arrives while `busy` is 1 has no effect on any output.
- R11: A freeze request when the channels are already frozen, or a thaw request when they are already thawed, still runs the full timed series and ends with the same outputs.
- R12: If `freeze_req` and `thaw_req` are both 1 while idle, a freeze series runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_req | input | 1 | Start a freeze series when idle |
| thaw_req | input | 1 | Start a thaw series when idle |
| slew_n | output | NUM_CH | Slew enable per channel, active-low |
| pullup_n | output | NUM_CH | Weak pull-up per channel, active-low |
| tri_n | output | NUM_CH | Tristate per channel, active-low |
| hold_n | output | NUM_CH | Bus-hold per channel, active-low |
| cfg_done | output | NUM_CH | Configuration-done per channel, active-high |
| frozen | output | NUM_CH | Per-channel status, 1 = frozen |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle end-of-series pulse |

## Verification
The bench compares every output in every cycle against a model of the step timing. It runs a thaw from the reset state, a repeated thaw, a freeze and a repeated freeze, which separates the per-step line order and gap counting from any dependence on the previous state. Requests injected in the middle of a series expose a design that fails to ignore them. Simultaneous freeze and thaw requests, issued from both the frozen and the thawed state, pin down the priority rule.

// File: rtl/io_freeze_seq.sv
module io_freeze_seq #(
  parameter int NUM_CH  = 3,
  parameter int CLK_MHZ = 200,
  parameter int GAP_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_req,
  input  logic              thaw_req,
  output logic [NUM_CH-1:0] slew_n,
  output logic [NUM_CH-1:0] pullup_n,
  output logic [NUM_CH-1:0] tri_n,
  output logic [NUM_CH-1:0] hold_n,
  output logic [NUM_CH-1:0] cfg_done,
  output logic [NUM_CH-1:0] frozen,
  output logic              busy,
  output logic              done
);
  localparam int GAP_RAW = (GAP_NS * CLK_MHZ + 999) / 1000;
  localparam int GAP     = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CW      = $clog2(GAP + 1);
  localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic           running, op_thaw, done_r;
  logic [CHW-1:0] ch;
  logic [1:0]     step;
  logic [CW-1:0]  cnt;

  logic           start, gap_end, last_step, last_ch, adv, fin, go, go_thaw;
  logic [CHW-1:0] go_ch;
  logic [1:0]     go_step;

  assign start     = !running && (freeze_req || thaw_req);
  assign gap_end   = running && (cnt == CW'(1));
  assign last_step = op_thaw ? (step == 2'd2) : (step == 2'd1);
  assign last_ch   = (ch == CHW'(NUM_CH - 1));
  assign fin       = gap_end && last_step && last_ch;
  assign adv       = gap_end && !(last_step && last_ch);
  assign go        = start || adv;
  assign go_thaw   = start ? !freeze_req : op_thaw;
  assign go_ch     = start ? '0 : (last_step ? CHW'(ch + 1'b1) : ch);
  assign go_step   = (start || last_step) ? 2'd0 : step + 2'd1;

  assign busy = running;
  assign done = done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      op_thaw <= 1'b0;
      done_r  <= 1'b0;
      ch      <= '0;
      step    <= 2'd0;
      cnt     <= '0;
    end else begin
      done_r <= fin;
      if (start) begin
        running <= 1'b1;
        op_thaw <= go_thaw;
      end else if (fin) begin
        running <= 1'b0;
      end
      if (go) begin
        ch   <= go_ch;
        step <= go_step;
        cnt  <= CW'(GAP);
      end else if (running && cnt > CW'(1)) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slew_n[i]   <= 1'b0;
        pullup_n[i] <= 1'b0;
        tri_n[i]    <= 1'b0;
        hold_n[i]   <= 1'b0;
        cfg_done[i] <= 1'b0;
        frozen[i]   <= 1'b1;
      end else if (go && go_ch == CHW'(i)) begin
        case ({go_thaw, go_step})
          3'b000: begin
            slew_n[i] <= 1'b0; pullup_n[i] <= 1'b0; tri_n[i] <= 1'b0;
          end
          3'b001: begin
            hold_n[i] <= 1'b0; cfg_done[i] <= 1'b0; frozen[i] <= 1'b1;
          end
          3'b100: begin
            hold_n[i] <= 1'b1; cfg_done[i] <= 1'b1;
          end
          3'b101: begin
            pullup_n[i] <= 1'b1; tri_n[i] <= 1'b1;
          end
          3'b110: begin
            slew_n[i] <= 1'b1; frozen[i] <= 1'b0;
          end
          default: ;
        endcase
      end
    end

    AST_FREEZE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_n[i]) |-> (!slew_n[i] && !pullup_n[i] && !tri_n[i])); // R3
    AST_SLEW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slew_n[i]) |-> (hold_n[i] && cfg_done[i] && pullup_n[i] && tri_n[i] && !frozen[i])); // R6
    AST_THAWED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !frozen[i] |-> (hold_n[i] && cfg_done[i])); // R3
  end

  logic [5*NUM_CH-1:0] pads, pads_q;
  logic [NUM_CH-1:0]   chg;
  logic [CW-1:0]       since;

  assign pads = {slew_n, pullup_n, tri_n, hold_n, cfg_done};
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chg
    assign chg[i] = (pads[i] ^ pads_q[i]) | (pads[NUM_CH+i] ^ pads_q[NUM_CH+i]) |
                    (pads[2*NUM_CH+i] ^ pads_q[2*NUM_CH+i]) |
                    (pads[3*NUM_CH+i] ^ pads_q[3*NUM_CH+i]) |
                    (pads[4*NUM_CH+i] ^ pads_q[4*NUM_CH+i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pads_q <= '0;
      since  <= CW'(GAP);
    end else begin
      pads_q <= pads;
      if (|chg)               since <= CW'(1);
      else if (since < CW'(GAP)) since <= since + CW'(1);
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg)); // R7
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> (since >= CW'(GAP))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
endmodule

// File: tb/tb_io_freeze_seq.sv
module tb_io_freeze_seq;
  localparam int NUM_CH = 3, CLK_MHZ = 200, GAP_NS = 20;
  localparam int GAP_R = (GAP_NS * CLK_MHZ + 999) / 1000;
  localparam int GAP = (GAP_R < 1) ? 1 : GAP_R;

  logic clk = 0, rst_n = 0, freeze_req = 0, thaw_req = 0;
  logic [2:0] slew_n, pullup_n, tri_n, hold_n, cfg_done, frozen;
  logic busy, done;

  io_freeze_seq #(.NUM_CH(NUM_CH), .CLK_MHZ(CLK_MHZ), .GAP_NS(GAP_NS)) dut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .slew_n(slew_n), .pullup_n(pullup_n), .tri_n(tri_n), .hold_n(hold_n),
    .cfg_done(cfg_done), .frozen(frozen), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  typedef struct { logic [19:0] v; string tag; } item_t;
  item_t q[$];
  int vectors = 0, errors = 0;
  bit finished = 0;

  logic [2:0] m_slew = 0, m_pu = 0, m_tri = 0, m_hold = 0, m_cfg = 0, m_frz = 3'b111;

  function automatic logic [19:0] snap(input logic b, input logic d);
    return {b, d, m_frz, m_cfg, m_hold, m_tri, m_pu, m_slew};
  endfunction

  function automatic logic [19:0] actual();
    return {busy, done, frozen, cfg_done, hold_n, tri_n, pullup_n, slew_n};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      vectors++;
      if (actual() !== e.v) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", e.tag, actual(), e.v);
      end
    end
  end

  task automatic push_step(input bit thw, input int s, input int c, input string base);
    string t;
    if (!thw && s == 0) begin m_slew[c] = 0; m_pu[c] = 0; m_tri[c] = 0; t = "R2"; end
    else if (!thw)      begin m_hold[c] = 0; m_cfg[c] = 0; m_frz[c] = 1; t = "R3"; end
    else if (s == 0)    begin m_hold[c] = 1; m_cfg[c] = 1; t = "R4"; end
    else if (s == 1)    begin m_pu[c] = 1; m_tri[c] = 1; t = "R5"; end
    else                begin m_slew[c] = 1; m_frz[c] = 0; t = "R6"; end
    for (int k = 0; k < GAP; k++)
      q.push_back('{snap(1, 0), $sformatf("%s R7 R8 ch%0d step%0d %s", t, c, s, base)});
  endtask

  task automatic run(input bit f, input bit t, input int poke, input bit pf, input bit pt,
                     input string base);
    bit thw;
    int ns;
    @(negedge clk); #1;
    freeze_req = f; thaw_req = t;
    thw = !f;
    ns = thw ? 3 : 2;
    for (int c = 0; c < NUM_CH; c++)
      for (int s = 0; s < ns; s++) push_step(thw, s, c, base);
    q.push_back('{snap(0, 1), {"R9 done ", base}});
    q.push_back('{snap(0, 0), {"R9 idle ", base}});
    @(negedge clk); #1;
    freeze_req = 0; thaw_req = 0;
    if (poke > 0) begin
      repeat (poke - 1) @(negedge clk);
      #1; freeze_req = pf; thaw_req = pt;
      @(negedge clk); #1;
      freeze_req = 0; thaw_req = 0;
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (actual() !== 20'h001C0 && actual() !== {2'b00, 3'b111, 15'h0}) begin
      errors++;
      $display("FAIL R1 in reset: actual %h expected %h", actual(), {2'b00, 3'b111, 15'h0});
    end
    #1 rst_n = 1;
    @(negedge clk);
    vectors++;
    if (actual() !== {2'b00, 3'b111, 15'h0}) begin
      errors++;
      $display("FAIL R1 after reset: actual %h expected %h", actual(), {2'b00, 3'b111, 15'h0});
    end
    run(0, 1, 0, 0, 0, "thaw from reset");
    run(0, 1, 0, 0, 0, "R11 repeat thaw");
    run(1, 0, 5, 0, 1, "R10 freeze with thaw poke");
    run(1, 0, 10, 1, 0, "R11 R10 repeat freeze with freeze poke");
    run(1, 1, 0, 0, 0, "R12 both while frozen");
    run(0, 1, 3 * GAP + 1, 1, 1, "R10 thaw with both poke");
    run(1, 1, 0, 0, 0, "R12 both while thawed");
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end
endmodule